// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is a synthesizable byte-wide synchronous memory. Every access is split in two. In the command cycle, the address and control inputs are sampled on a rising edge. In the data cycle, which is the following enabled cycle, the data moves. Reads and writes can be mixed freely at one operation per clock, with no idle cycle when the bus changes direction.

Read data is flow-through. The array is read combinationally at the registered address during the data cycle. Write data is taken on the edge that closes the data cycle. An active-low clock enable freezes the whole pipeline, including an operation that is waiting for its data cycle. An active-low chip select, when high, starts nothing new but lets a pending data cycle finish. The bidirectional bus is modelled as a data-out port with a drive flag, and an asynchronous output enable gates that flag.

The pending-phase state machine has three states:
- `PH_IDLE`: no data cycle is pending.
- `PH_READ`: a read data cycle is in progress.
- `PH_WRITE`: a write data cycle is in progress.

It has three transitions:
- `hold`: clock enable is high, so the state is kept.
- `deselect`: clock enable is low and chip select is high, so the next state is `PH_IDLE`.
- `issue`: clock enable and chip select are low, so the next state is `PH_READ` or `PH_WRITE` according to write enable.

Each of these transitions is taken from any state.

Top module: `zbt_sram_core`

## Requirements
- R1: While reset is asserted, and after it is released, the state is `PH_IDLE`. The drive flag stays low and nothing is written until the first enabled, selected command.
- R2: When an enabled, selected edge samples write enable high (read), the byte stored at the sampled address appears on `dout` during the next cycle. In that cycle `dout_drive` is 1 if `oe_n` is 0.
- R3: When an enabled, selected edge samples write enable low (write), the array stores the `din` value present at the next enabled rising edge.
- R4: When `cke_n` is sampled high, no input has any effect. The pending data cycle and the registered address are kept, so a held read shows the same byte again. A held write takes `din` at the first edge after the stall where `cke_n` is low.
- R5: When an enabled edge samples `sel_n` high, no new operation starts. In the following cycle `dout_drive` is 0, and any pending write still completes at that edge.
- R6: Write enable has no effect when `sel_n` is sampled high. The stored byte at the presented address is unchanged.
- R7: While `oe_n` is 1, `dout_drive` is 0 and `dout` is 0 in the same cycle, independent of the clock.
- R8: Any sequence of reads and writes runs at one operation per clock. This includes a read issued on the edge right after a write to the same address, and that read returns the newly written byte.
- R9: During write data cycles and idle cycles, `dout_drive` is 0 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write enable (1 = read) |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Command address |
| din | input | DATA_W | Write data, taken at the edge ending the data cycle |
| dout | output | DATA_W | Flow-through read data, 0 when not driven |
| dout_drive | output | 1 | High when the block would drive the data bus |

## Verification
The hardest situation to reach is a write whose data cycle is stretched by one or more clock-enable stalls while `din` keeps changing. In that case only the value at the first enabled edge may land in the array. A close second is a read of an address whose write completed only one edge earlier. Directed sequences build both cases explicitly, with junk data during the stalls, and then read the affected addresses back. Constrained-random traffic over a small address window produces many more such collisions, stalls and deselects, all checked against a bench reference model.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;
endpackage

// File: rtl/zbt_phase_ctrl.sv
module zbt_phase_ctrl
    import zbt_sram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output phase_e            phase,
    output logic [ADDR_W-1:0] pend_addr,
    output logic              mem_we,
    output logic              rd_phase
);
    phase_e phase_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            pend_addr <= '0;
        end else begin
            phase <= phase_nxt;
            if (!cke_n && !sel_n) begin
                pend_addr <= addr;
            end
        end
    end

    // transitions: hold, deselect, issue
    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE, PH_READ, PH_WRITE: begin
                if (cke_n)      phase_nxt = phase;
                else if (sel_n) phase_nxt = PH_IDLE;
                else            phase_nxt = wr_n ? PH_READ : PH_WRITE;
            end
            default: phase_nxt = PH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_we   = (phase == PH_WRITE) && !cke_n;
        rd_phase = (phase == PH_READ);
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> phase == PH_IDLE);

    assert_read_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !sel_n && wr_n) |=> phase == PH_READ);

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> ($stable(phase) && $stable(pend_addr)));

    assert_deselect_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && sel_n) |=> phase == PH_IDLE);
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    assert_write_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !cke_n);
endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
    import zbt_sram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_drive
);
    phase_e            phase;
    logic [ADDR_W-1:0] pend_addr;
    logic              mem_we;
    logic              rd_phase;
    logic [DATA_W-1:0] rdata;

    zbt_phase_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cke_n     (cke_n),
        .sel_n     (sel_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .phase     (phase),
        .pend_addr (pend_addr),
        .mem_we    (mem_we),
        .rd_phase  (rd_phase)
    );

    zbt_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .cke_n (cke_n),
        .we    (mem_we),
        .addr  (pend_addr),
        .wdata (din),
        .rdata (rdata)
    );

    always_comb begin
        dout_drive = rd_phase && !oe_n;
        dout       = dout_drive ? rdata : '0;
    end

    assert_no_drive_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_READ) |-> !dout_drive);

    assert_oe_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!dout_drive && dout == '0));
endmodule

// File: tb/tb_zbt_sram_core.sv
`timescale 1ns/1ps
module tb_zbt_sram_core;
    localparam int AW = 10;
    localparam int DW = 8;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          cke_n = 1, sel_n = 1, wr_n = 1, oe_n = 1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_drive;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    logic [DW-1:0] rmem [16];
    bit            m_pv = 0, m_pw = 0;
    logic [3:0]    m_pa = '0;

    zbt_sram_core #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel_n(sel_n), .wr_n(wr_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_drive(dout_drive)
    );

    always #5 clk = ~clk;

    function automatic bit exp_drive(bit oe);
        return m_pv && !m_pw && !oe;
    endfunction

    function automatic logic [DW-1:0] exp_data(bit oe);
        return exp_drive(oe) ? rmem[m_pa] : '0;
    endfunction

    function automatic string auto_tag(bit oe);
        if (oe)           return "R7";
        if (!m_pv)        return "R5";
        if (m_pw)         return "R9";
        return "R2";
    endfunction

    task automatic check(string tag);
        bit            ed;
        logic [DW-1:0] ev;
        ed = exp_drive(oe_n);
        ev = exp_data(oe_n);
        n_cmp++;
        if (dout_drive !== ed || dout !== ev) begin
            n_bad++;
            $display("FAIL %s: drive=%0b dout=%02h expected drive=%0b dout=%02h",
                     tag, dout_drive, dout, ed, ev);
        end
    endtask

    // one clock: drive at negedge, check, then update model at posedge
    task automatic cyc(bit ck, bit sl, bit wr, bit oe, logic [3:0] a,
                       logic [DW-1:0] d, string tag);
        @(negedge clk);
        cke_n = ck; sel_n = sl; wr_n = wr; oe_n = oe;
        addr = AW'(a); din = d;
        #1;
        check(tag == "" ? auto_tag(oe) : tag);
        @(posedge clk);
        if (!ck) begin
            if (m_pv && m_pw) rmem[m_pa] = d;
            m_pv = !sl;
            m_pw = !wr;
            m_pa = a;
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: no drive while in reset
        n_cmp++;
        if (dout_drive !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: drive=%0b expected drive=0", dout_drive);
        end
        rst_n = 1;
        cyc(0, 1, 1, 0, 0, 8'h00, "R1");
        // prefill addresses 0..15 back to back (R3)
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, 4'(i), 8'(i * 7 + 3), "R3");
        cyc(0, 1, 1, 0, 0, 8'hEE, "R3");
        // R2: plain read
        cyc(0, 0, 1, 0, 4'd3, 8'h00, "R2");
        // R4: read held through stall
        cyc(0, 0, 1, 0, 4'd4, 8'h00, "R2");
        cyc(1, 0, 0, 0, 4'd9, 8'h77, "R4");
        cyc(1, 1, 0, 0, 4'd8, 8'h66, "R4");
        // R4: write stalled with junk data, then real data
        cyc(0, 0, 0, 0, 4'd5, 8'h11, "R4");
        cyc(1, 0, 1, 0, 4'd6, 8'h22, "R4");
        cyc(1, 0, 1, 0, 4'd6, 8'h33, "R4");
        cyc(0, 0, 1, 0, 4'd5, 8'hA5, "R4");
        cyc(0, 1, 1, 0, 4'd0, 8'h00, "R4");
        // R6: write enable low while deselected
        cyc(0, 1, 0, 0, 4'd7, 8'h5A, "R6");
        cyc(0, 0, 1, 0, 4'd7, 8'h00, "R6");
        cyc(0, 1, 1, 0, 4'd0, 8'h00, "R6");
        // R8: alternation and read right after write to same address
        cyc(0, 0, 0, 0, 4'd9, 8'h00, "R8");
        cyc(0, 0, 1, 0, 4'd9, 8'hC3, "R8");
        cyc(0, 0, 0, 0, 4'd10, 8'h00, "R8");
        cyc(0, 0, 1, 0, 4'd9, 8'h3C, "R8");
        cyc(0, 0, 1, 0, 4'd10, 8'h00, "R8");
        // R7: output enable high on a read data cycle
        cyc(0, 0, 1, 1, 4'd2, 8'h00, "R7");
        cyc(0, 1, 1, 1, 4'd2, 8'h00, "R7");
        // R5: pending write completes at deselect edge
        cyc(0, 0, 0, 0, 4'd11, 8'h00, "R5");
        cyc(0, 1, 1, 0, 4'd0, 8'h9D, "R5");
        cyc(0, 0, 1, 0, 4'd11, 8'h00, "R5");
        cyc(0, 1, 1, 0, 4'd0, 8'h00, "R5");
        // constrained random traffic
        for (int k = 0; k < 3000; k++) begin
            cyc(($urandom % 5) == 0, ($urandom % 6) == 0, 1'($urandom % 2),
                ($urandom % 8) == 0, 4'($urandom % 16), 8'($urandom), "");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule